// File: doc/BRIEF.md
# Subtract-and-branch processor core

This block is a tiny processor whose whole instruction set is one operation: subtract one data word from another, store the difference, and branch if that difference is zero or negative. It keeps instructions and operands in two separate memories. Each memory has its own host port on its own clock. A host loads both memories while the core is idle and then holds the activate input high to let the program run.

Each instruction names two data cells, A and B, and a program address C. The core computes cell B minus cell A, writes the difference into cell B, and then either jumps to C or goes on to the next program address. An unconditional jump is written by naming one zero-valued cell as both A and B. A halt is written as an instruction that jumps to its own address. The program counter, a running flag and the outcome of the last branch test are visible at the ports. The host can read both memories back at any time.

Top module: `subleq_core`

## Requirements
- R1: An instruction word is 16 bits wide with the default sizes. Bits [15:12] hold data address A, bits [11:8] hold data address B, and bits [7:0] hold program address C.
- R2: Executing an instruction writes (cell B − cell A) into cell B. The subtraction is done modulo 2^8 on two's-complement words, so −128 − 1 stores 127. Cell A is left unchanged when A differs from B.
- R3: If the stored difference, read as a signed value, is ≤ 0, the program counter becomes C. Otherwise it becomes PC + 1. leqFlag shows the result of that test (1 = branch taken) from the retirement of the instruction onward.
- R4: An instruction whose A and B are the same zero-valued cell always branches and leaves that cell at 0.
- R5: An instruction with C equal to its own address keeps the program counter at that address for every later retirement.
- R6: While clear is high on a core clock edge, the core sets pc to 0 and drops running and leqFlag to 0. During clear, activate has no effect.
- R7: running goes to 1 on the first core edge that samples activate high after clear, and goes to 0 on the first core edge that samples it low. While activate is low, pc does not change.
- R8: Each instruction takes exactly 4 core cycles. The first instruction retires on the 4th core edge after the edge that raised running. pc and leqFlag change only on those retirement edges.
- R9: A program-port write stores the word at progAddr on a progClk edge. progRdata shows the word at progAddr one progClk edge after the address is applied.
- R10: A data-port write stores the word at dataAddr on a dataClk edge. dataRdata shows the current content of the cell at dataAddr one dataClk edge after the address is applied, and that content includes values the core has written. After a clear, the values written by the host are visible again in every cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| progClk | input | 1 | Clock of the host program port |
| progWe | input | 1 | Program write enable |
| progAddr | input | 8 | Program write and readback address |
| progWdata | input | 16 | Instruction word to store |
| progRdata | output | 16 | Instruction readback, one progClk edge latency |
| dataClk | input | 1 | Clock of the host data port |
| dataWe | input | 1 | Data write enable |
| dataAddr | input | 4 | Data write and readback address |
| dataWdata | input | 8 | Signed data word to store |
| dataRdata | output | 8 | Data readback, one dataClk edge latency |
| coreClk | input | 1 | Execution clock |
| clear | input | 1 | Synchronous clear of the core |
| activate | input | 1 | Run enable |
| running | output | 1 | Core is executing |
| pc | output | 8 | Program counter, updated on retirement |
| leqFlag | output | 1 | Result of the last ≤ 0 test |

## Verification
running is due one core edge after activate changes. An instruction's pc and leqFlag are due exactly four core edges after the previous retirement, or after the activating edge for the first instruction. Both host readbacks are due one edge of their port clock after the address is applied. The bench drives inputs and samples outputs on falling edges and counts rising edges between them. For each instruction it checks that pc still holds the old value after the third edge and holds the new value after the fourth, so an early or late update is caught. Memory contents are read back through the host data port once the program has reached its halt loop.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

  // Phases of one instruction
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_READA,
    S_READB,
    S_EXEC
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadIr;   // latch instruction, address data port with field A
    logic loadA;    // latch operand A, address data port with field B
    logic retire;   // write back difference, update pc and flag
  } ctl_t;

endpackage

// File: rtl/subleq_prog_mem.sv
module subleq_prog_mem #(
  parameter int AW = 8,
  parameter int WW = 16
) (
  input  logic          hostClk,
  input  logic          hostWe,
  input  logic [AW-1:0] hostAddr,
  input  logic [WW-1:0] hostWdata,
  output logic [WW-1:0] hostRdata,
  input  logic          coreClk,
  input  logic [AW-1:0] coreAddr,
  output logic [WW-1:0] coreRdata
);
  localparam int DEPTH = 2 ** AW;

  logic [WW-1:0] store [DEPTH];

  always_ff @(posedge hostClk) begin
    if (hostWe) store[hostAddr] <= hostWdata;
    hostRdata <= store[hostAddr];
  end

  always_ff @(posedge coreClk) begin
    coreRdata <= store[coreAddr];
  end
endmodule

// File: rtl/subleq_data_mem.sv
module subleq_data_mem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          hostClk,
  input  logic          hostWe,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWdata,
  output logic [DW-1:0] hostRdata,
  input  logic          coreClk,
  input  logic          clear,
  input  logic          coreWe,
  input  logic [AW-1:0] coreAddr,
  input  logic [DW-1:0] coreWdata,
  output logic [DW-1:0] coreRdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0]    hostMem [DEPTH];
  logic [DW-1:0]    coreMem [DEPTH];
  logic [DW-1:0]    merged  [DEPTH];
  logic [DEPTH-1:0] owned;

  // A cell written by the core since clear shows the core copy
  for (genvar i = 0; i < DEPTH; i++) begin : g_merge
    assign merged[i] = owned[i] ? coreMem[i] : hostMem[i];
  end

  always_ff @(posedge hostClk) begin
    if (hostWe) hostMem[hostAddr] <= hostWdata;
    hostRdata <= merged[hostAddr];
  end

  always_ff @(posedge coreClk) begin
    if (clear) begin
      owned <= '0;
    end else if (coreWe) begin
      owned[coreAddr]   <= 1'b1;
      coreMem[coreAddr] <= coreWdata;
    end
    coreRdata <= merged[coreAddr];
  end
endmodule

// File: rtl/subleq_control.sv
module subleq_control
  import subleq_pkg::*;
(
  input  logic coreClk,
  input  logic clear,
  input  logic activate,
  output logic running,
  output ctl_t ctl
);
  phase_t phase;

  always_ff @(posedge coreClk) begin
    if (clear) begin
      phase   <= S_IDLE;
      running <= 1'b0;
    end else begin
      running <= activate;
      if (!activate) begin
        phase <= S_IDLE;
      end else begin
        unique case (phase)
          S_IDLE:  phase <= S_FETCH;
          S_FETCH: phase <= S_READA;
          S_READA: phase <= S_READB;
          S_READB: phase <= S_EXEC;
          S_EXEC:  phase <= S_FETCH;
          default: phase <= S_IDLE;
        endcase
      end
    end
  end

  // Strobes are suppressed the moment activate drops, so an aborted
  // instruction leaves neither memory nor pc touched
  always_comb begin
    ctl        = '0;
    ctl.loadIr = activate && (phase == S_READA);
    ctl.loadA  = activate && (phase == S_READB);
    ctl.retire = activate && (phase == S_EXEC);
  end
endmodule

// File: rtl/subleq_datapath.sv
module subleq_datapath
  import subleq_pkg::*;
#(
  parameter int PAW = 8,
  parameter int DAW = 4,
  parameter int DW  = 8
) (
  input  logic                 coreClk,
  input  logic                 clear,
  input  ctl_t                 ctl,
  input  logic [2*DAW+PAW-1:0] progRd,
  input  logic [DW-1:0]        dataRd,
  output logic [DAW-1:0]       memAddr,
  output logic                 memWe,
  output logic [DW-1:0]        memWdata,
  output logic [PAW-1:0]       pc,
  output logic                 leqFlag
);
  localparam int IW = 2 * DAW + PAW;

  logic [DAW-1:0] fieldA;
  logic [DAW-1:0] fieldB;
  logic [PAW-1:0] fieldC;
  logic [DAW-1:0] irB;
  logic [PAW-1:0] irC;
  logic [DW-1:0]  opA;
  logic [DW-1:0]  diff;
  logic           leqNow;

  assign fieldA = progRd[IW-1 -: DAW];
  assign fieldB = progRd[IW-1-DAW -: DAW];
  assign fieldC = progRd[PAW-1:0];

  assign diff   = dataRd - opA;
  assign leqNow = diff[DW-1] || (diff == '0);

  assign memAddr  = ctl.loadIr ? fieldA : irB;
  assign memWe    = ctl.retire;
  assign memWdata = diff;

  always_ff @(posedge coreClk) begin
    if (ctl.loadIr) begin
      irB <= fieldB;
      irC <= fieldC;
    end
    if (ctl.loadA) opA <= dataRd;
  end

  always_ff @(posedge coreClk) begin
    if (clear) begin
      pc      <= '0;
      leqFlag <= 1'b0;
    end else if (ctl.retire) begin
      pc      <= leqNow ? irC : pc + 1'b1;
      leqFlag <= leqNow;
    end
  end
endmodule

// File: rtl/subleq_core.sv
module subleq_core
  import subleq_pkg::*;
#(
  parameter int PAW = 8,
  parameter int DAW = 4,
  parameter int DW  = 8
) (
  input  logic                 progClk,
  input  logic                 progWe,
  input  logic [PAW-1:0]       progAddr,
  input  logic [2*DAW+PAW-1:0] progWdata,
  output logic [2*DAW+PAW-1:0] progRdata,
  input  logic                 dataClk,
  input  logic                 dataWe,
  input  logic [DAW-1:0]       dataAddr,
  input  logic [DW-1:0]        dataWdata,
  output logic [DW-1:0]        dataRdata,
  input  logic                 coreClk,
  input  logic                 clear,
  input  logic                 activate,
  output logic                 running,
  output logic [PAW-1:0]       pc,
  output logic                 leqFlag
);
  localparam int IW = 2 * DAW + PAW;

  ctl_t           ctl;
  logic [IW-1:0]  progRd;
  logic [DW-1:0]  dataRd;
  logic [DAW-1:0] memAddr;
  logic           memWe;
  logic [DW-1:0]  memWdata;

  subleq_prog_mem #(.AW(PAW), .WW(IW)) u_prog (
    .hostClk(progClk), .hostWe(progWe), .hostAddr(progAddr),
    .hostWdata(progWdata), .hostRdata(progRdata),
    .coreClk(coreClk), .coreAddr(pc), .coreRdata(progRd)
  );

  subleq_data_mem #(.AW(DAW), .DW(DW)) u_data (
    .hostClk(dataClk), .hostWe(dataWe), .hostAddr(dataAddr),
    .hostWdata(dataWdata), .hostRdata(dataRdata),
    .coreClk(coreClk), .clear(clear), .coreWe(memWe),
    .coreAddr(memAddr), .coreWdata(memWdata), .coreRdata(dataRd)
  );

  subleq_control u_ctl (
    .coreClk(coreClk), .clear(clear), .activate(activate),
    .running(running), .ctl(ctl)
  );

  subleq_datapath #(.PAW(PAW), .DAW(DAW), .DW(DW)) u_dp (
    .coreClk(coreClk), .clear(clear), .ctl(ctl),
    .progRd(progRd), .dataRd(dataRd),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .pc(pc), .leqFlag(leqFlag)
  );
endmodule

// File: rtl/subleq_core_checker.sv
module subleq_core_checker #(
  parameter int PAW = 8
) (
  input logic           coreClk,
  input logic           clear,
  input logic           activate,
  input logic [PAW-1:0] pc,
  input logic           leqFlag,
  input logic           loadIr,
  input logic           loadA,
  input logic           retire
);
  // R8: pc moves only on a retirement edge
  a_r8_pc_moves_on_retire: assert property (@(posedge coreClk) disable iff (clear)
    !$stable(pc) |-> $past(retire));

  // R7: with activate low, the next edge leaves pc alone
  a_r7_idle_holds_pc: assert property (@(posedge coreClk) disable iff (clear)
    !activate |=> $stable(pc));

  // R3: a retirement without branch advances pc by one
  a_r3_fallthrough: assert property (@(posedge coreClk) disable iff (clear)
    ($past(retire) && !leqFlag) |-> (pc == PAW'($past(pc) + 1'b1)));

  // R8: at most one phase strobe at a time
  a_r8_strobes_exclusive: assert property (@(posedge coreClk) disable iff (clear)
    $onehot0({loadIr, loadA, retire}));

  // R8: retirements are never back to back
  a_r8_retire_spacing: assert property (@(posedge coreClk) disable iff (clear)
    retire |=> !retire);
endmodule

bind subleq_core subleq_core_checker #(.PAW(PAW)) u_checker (
  .coreClk(coreClk), .clear(clear), .activate(activate),
  .pc(pc), .leqFlag(leqFlag),
  .loadIr(ctl.loadIr), .loadA(ctl.loadA), .retire(ctl.retire)
);

// File: tb/subleq_core_bench.sv
module subleq_core_bench;
  localparam int PAW = 8;
  localparam int DAW = 4;
  localparam int DW  = 8;
  localparam int IW  = 2 * DAW + PAW;

  logic           clk = 1'b0;
  logic           progWe = 1'b0;
  logic [PAW-1:0] progAddr = '0;
  logic [IW-1:0]  progWdata = '0;
  logic [IW-1:0]  progRdata;
  logic           dataWe = 1'b0;
  logic [DAW-1:0] dataAddr = '0;
  logic [DW-1:0]  dataWdata = '0;
  logic [DW-1:0]  dataRdata;
  logic           clear = 1'b1;
  logic           activate = 1'b0;
  logic           running;
  logic [PAW-1:0] pc;
  logic           leqFlag;

  int checks = 0;
  int fails  = 0;
  logic [PAW-1:0] lastPc;

  always #4 clk = ~clk;   // 125 MHz

  subleq_core u_subleq_core (
    .progClk(clk), .progWe(progWe), .progAddr(progAddr),
    .progWdata(progWdata), .progRdata(progRdata),
    .dataClk(clk), .dataWe(dataWe), .dataAddr(dataAddr),
    .dataWdata(dataWdata), .dataRdata(dataRdata),
    .coreClk(clk), .clear(clear), .activate(activate),
    .running(running), .pc(pc), .leqFlag(leqFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] inst(input int a, input int b, input int c);
    return {DAW'(a), DAW'(b), PAW'(c)};
  endfunction

  task automatic writeProg(input int addr, input logic [IW-1:0] word);
    progAddr = PAW'(addr); progWdata = word; progWe = 1'b1;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  task automatic writeData(input int addr, input int val);
    dataAddr = DAW'(addr); dataWdata = DW'(val); dataWe = 1'b1;
    @(negedge clk);
    dataWe = 1'b0;
  endtask

  task automatic readData(input int addr, output logic [DW-1:0] val);
    dataAddr = DAW'(addr);
    @(negedge clk);
    val = dataRdata;
  endtask

  // Called right after a retirement or the activating edge
  task automatic step(input string req, input int expPc, input logic expLeq);
    repeat (3) @(negedge clk);
    check({"R8 pc held before retire ", req}, 32'(pc), 32'(lastPc));
    @(negedge clk);
    check({req, " pc"}, 32'(pc), 32'(expPc));
    check({req, " leqFlag"}, 32'(leqFlag), 32'(expLeq));
    lastPc = PAW'(expPc);
  endtask

  task automatic startRun();
    activate = 1'b1;
    @(negedge clk);
    check("R7 running rises", 32'(running), 32'd1);
    lastPc = pc;
  endtask

  task automatic testReset();
    repeat (2) @(negedge clk);
    check("R6 pc after clear", 32'(pc), 32'd0);
    check("R6 running after clear", 32'(running), 32'd0);
    check("R6 leqFlag after clear", 32'(leqFlag), 32'd0);
    activate = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 activate ignored during clear", 32'(running), 32'd0);
    check("R6 pc stays during clear", 32'(pc), 32'd0);
    activate = 1'b0;
    clear = 1'b0;
    @(negedge clk);
  endtask

  task automatic testLoadAndGate();
    logic [DW-1:0] v;
    writeProg(0,   inst(0, 0, 8));
    writeProg(8,   inst(1, 0, 9));
    writeProg(9,   inst(0, 2, 10));
    writeProg(10,  inst(0, 0, 11));
    writeProg(11,  inst(0, 0, 255));
    writeProg(255, inst(0, 0, 255));
    writeData(0, 0);
    writeData(1, 12);
    writeData(2, 34);
    progAddr = 8'd9;
    @(negedge clk);
    check("R1 R9 program readback field layout", 32'(progRdata), 32'h020A);
    readData(1, v);
    check("R10 data readback", 32'(v), 32'd12);
    repeat (5) @(negedge clk);
    check("R7 no run without activate", 32'(running), 32'd0);
    check("R7 pc held without activate", 32'(pc), 32'd0);
  endtask

  task automatic testAddProgram();
    logic [DW-1:0] v;
    startRun();
    step("R4 jump over gap", 8, 1'b1);
    step("R3 negative difference branches", 9, 1'b1);
    step("R3 positive difference falls through", 10, 1'b0);
    step("R4 zero cell jump", 11, 1'b1);
    step("R4 jump to halt", 255, 1'b1);
    step("R5 halt loop", 255, 1'b1);
    step("R5 halt loop again", 255, 1'b1);
    readData(2, v);
    check("R2 sum cell", 32'(v), 32'd46);
    readData(0, v);
    check("R4 zero cell restored", 32'(v), 32'd0);
    readData(1, v);
    check("R2 operand A unchanged", 32'(v), 32'd12);
  endtask

  task automatic testDeactivate();
    activate = 1'b0;
    @(negedge clk);
    check("R7 running falls", 32'(running), 32'd0);
    repeat (8) @(negedge clk);
    check("R7 pc frozen while inactive", 32'(pc), 32'd255);
  endtask

  task automatic testWrapAndBranch();
    logic [DW-1:0] v;
    clear = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 pc cleared again", 32'(pc), 32'd0);
    check("R6 leqFlag cleared again", 32'(leqFlag), 32'd0);
    clear = 1'b0;
    writeData(3, 1);
    writeData(4, 8'h80);
    writeData(6, 5);
    writeData(7, 3);
    writeData(2, 7);
    readData(2, v);
    check("R10 host value visible after clear", 32'(v), 32'd7);
    writeProg(0,  inst(3, 4, 20));
    writeProg(1,  inst(6, 7, 40));
    writeProg(40, inst(2, 2, 40));
    startRun();
    step("R2 wrapped difference falls through", 1, 1'b0);
    step("R3 negative difference jumps far", 40, 1'b1);
    step("R5 self jump", 40, 1'b1);
    readData(4, v);
    check("R2 wrap stores 127", 32'(v), 32'h7F);
    readData(7, v);
    check("R2 negative result stored", 32'(v), 32'hFE);
    readData(2, v);
    check("R4 same cell subtract gives zero", 32'(v), 32'd0);
    activate = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    testReset();
    testLoadAndGate();
    testAddProgram();
    testDeactivate();
    testWrapAndBranch();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule